// File: doc/BRIEF.md
# Dual-Reload-Count PWM Timer

A single timer channel that produces a rectangular waveform on one output pin from a down-counter. Software sets it up through a small register port: a control word, a first reload count and a second reload count. The counter runs from one reload value down to zero, then reloads for the next phase and flips the output.

The control word has an enable flag and a mode flag. With the mode flag set, the block works as a two-count pulse-width modulator. The active phase is driven low and lasts first-count + 1 clocks. The inactive phase is driven high and lasts second-count + 1 clocks. With the mode flag clear, the second count is unused and both phases last first-count + 1 clocks, so the output is a symmetric square wave. While the enable flag is clear, the counter is halted and the pin sits at its idle high level.

Reloads happen only at a terminal count, so a new count or mode value is picked up at the next phase boundary and never cuts a phase short.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset, `pwm_out` is 1 and all three registers read as 0.
- R2: The register select `wr_addr`/`rd_addr` works as follows: 0 is control (bit 0 = enable, bit 1 = PWM mode, all other bits read 0), 1 is the first count, 2 is the second count, and 3 reads 0. `rd_data` combinationally returns the value written.
- R3: Once a write that sets enable has been captured, `pwm_out` goes low on the following clock. The active phase starts from a freshly loaded first count.
- R4: With PWM mode set, the low phase lasts first-count + 1 clocks and the high phase lasts second-count + 1 clocks, so one period is the sum of the two.
- R5: With PWM mode clear, the second count has no effect. Both phases last first-count + 1 clocks (50% duty).
- R6: A count of 0 gives a phase exactly one clock long, in either mode.
- R7: A count or mode write made during a phase does not change that phase's length. It applies from the next phase boundary, where the mode bit selects which count the inactive phase uses.
- R8: One clock after a clear of enable is captured, `pwm_out` is 1, and it stays 1 while the timer is disabled. A later re-enable starts a full active phase from the first count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register selected for writing |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register selected for reading |
| rd_data | output | 32 | Read data (combinational) |
| pwm_out | output | 1 | Waveform output, idle high, active low |

## Verification
The bench measures phase lengths with unequal counts in both modes. A design that swapped the two counts, or that used the second count in symmetric mode, would give the wrong high-phase length. It writes zero counts to expose off-by-one errors: an off-by-one design would give two-clock phases or stall at zero. It changes a count and the mode bit in the middle of a phase. A design that reloaded at once would shorten or stretch the running phase, and one that latched the mode bit only at enable would keep the old high-phase length. It also disables the timer mid-phase and then re-enables it. A design that did not reload on restart would resume with a partial active phase.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int REG_SEL_W = 2;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CNT_A = 2'd1,
    SEL_CNT_B = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_DUAL_BIT = 1;

  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_REST   = 1'b1
  } phase_e;

  typedef struct packed {
    logic dual;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [REG_SEL_W-1:0] rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output ctrl_t                ctrl,
  output logic [CNT_W-1:0]     cnt_a,
  output logic [CNT_W-1:0]     cnt_b
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_a_q, cnt_a_d;
  logic [CNT_W-1:0] cnt_b_q, cnt_b_d;
  logic             ctrl_we, cnt_a_we, cnt_b_we;

  always_comb begin
    ctrl_we  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
    cnt_a_we = wr_en && (reg_sel_e'(wr_addr) == SEL_CNT_A);
    cnt_b_we = wr_en && (reg_sel_e'(wr_addr) == SEL_CNT_B);
    ctrl_d.run  = wr_data[CTRL_RUN_BIT];
    ctrl_d.dual = wr_data[CTRL_DUAL_BIT];
    cnt_a_d  = wr_data;
    cnt_b_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a_q <= '0;
    end else if (cnt_a_we) begin
      cnt_a_q <= cnt_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_b_q <= '0;
    end else if (cnt_b_we) begin
      cnt_b_q <= cnt_b_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_addr))
      SEL_CTRL: begin
        rd_data[CTRL_RUN_BIT]  = ctrl_q.run;
        rd_data[CTRL_DUAL_BIT] = ctrl_q.dual;
      end
      SEL_CNT_A: rd_data = cnt_a_q;
      SEL_CNT_B: rd_data = cnt_b_q;
      SEL_NONE:  rd_data = '0;
      default:   rd_data = '0;
    endcase
  end

  assign ctrl  = ctrl_q;
  assign cnt_a = cnt_a_q;
  assign cnt_b = cnt_b_q;

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_ce;

  always_comb begin
    count_ce = load || dec;
    if (load) begin
      count_d = load_val;
    end else begin
      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_ce) begin
      count_q <= count_d;
    end
  end

  assign count   = count_q;
  assign at_zero = (count_q == '0);

endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic             at_zero,
  output logic             load,
  output logic             dec,
  output logic [CNT_W-1:0] load_val,
  output logic             running,
  output phase_e           phase
);

  logic   run_q, run_d;
  phase_e phase_q, phase_d;
  logic   state_ce;

  always_comb begin
    run_d    = run_q;
    phase_d  = phase_q;
    load     = 1'b0;
    dec      = 1'b0;
    load_val = cnt_a;
    if (!ctrl.run) begin
      run_d   = 1'b0;
      phase_d = PH_ACTIVE;
    end else if (!run_q) begin
      run_d    = 1'b1;
      phase_d  = PH_ACTIVE;
      load     = 1'b1;
      load_val = cnt_a;
    end else if (at_zero) begin
      load = 1'b1;
      if (phase_q == PH_ACTIVE) begin
        phase_d  = PH_REST;
        load_val = ctrl.dual ? cnt_b : cnt_a;
      end else begin
        phase_d  = PH_ACTIVE;
        load_val = cnt_a;
      end
    end else begin
      dec = 1'b1;
    end
    state_ce = (run_d != run_q) || (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= PH_ACTIVE;
    end else if (state_ce) begin
      run_q   <= run_d;
      phase_q <= phase_d;
    end
  end

  assign running = run_q;
  assign phase   = phase_q;

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt_a, cnt_b, load_val, cnt_q;
  logic             load, dec, at_zero, run_q;
  phase_e           phase_q;
  logic             ctl_en, ctl_dual, phase_is_active;

  pwm_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctrl    (ctrl),
    .cnt_a   (cnt_a),
    .cnt_b   (cnt_b)
  );

  pwm_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .at_zero  (at_zero),
    .load     (load),
    .dec      (dec),
    .load_val (load_val),
    .running  (run_q),
    .phase    (phase_q)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (dec),
    .load_val (load_val),
    .count    (cnt_q),
    .at_zero  (at_zero)
  );

  assign ctl_en          = ctrl.run;
  assign ctl_dual        = ctrl.dual;
  assign phase_is_active = (phase_q == PH_ACTIVE);
  assign pwm_out         = !(run_q && phase_is_active);

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             ctl_dual,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic             running,
  input logic             phase_active,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_out
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> pwm_out);                                             // R8

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !running) |=> !pwm_out);                               // R3

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !running) |=> (cnt == $past(cnt_a)));                  // R3

  AST_HOLD_MIDPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && running && cnt != '0) |=> ($stable(pwm_out) && $stable(phase_active))); // R7

  AST_TOGGLE_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && running && cnt == '0) |=> (pwm_out != $past(pwm_out))); // R4

  AST_DUAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && running && cnt == '0 && phase_active && ctl_dual)
      |=> (cnt == $past(cnt_b)));                                      // R4

  AST_SYM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && running && cnt == '0 && phase_active && !ctl_dual)
      |=> (cnt == $past(cnt_a)));                                      // R5

endmodule

bind pwm_dual_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_en       (ctl_en),
  .ctl_dual     (ctl_dual),
  .cnt_a        (cnt_a),
  .cnt_b        (cnt_b),
  .running      (run_q),
  .phase_active (phase_is_active),
  .cnt          (cnt_q),
  .pwm_out      (pwm_out)
);

// File: tb/tb_pwm_dual_timer.sv
module tb_pwm_dual_timer;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [1:0]   rd_addr;
  logic [W-1:0] rd_data;
  logic         pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read sel %0d", a), rd_data, exp);
  endtask

  // Called at the negedge where a phase begins; returns at the negedge where the next begins.
  task automatic run_phase(output int len, output logic lvl);
    lvl = pwm_out;
    len = 1;
    while (len < 10000) begin
      @(negedge clk);
      if (pwm_out !== lvl) break;
      len++;
    end
  endtask

  task automatic stop_timer();
    wr(2'd0, 32'd0);
    @(negedge clk);
  endtask

  task automatic start_timer(input logic [W-1:0] c, input string req);
    wr(2'd0, c);
    chk(req, "high before start edge", pwm_out, 1);
    @(negedge clk);
    chk(req, "low one clock after enable", pwm_out, 0);
  endtask

  task automatic expect_phase(input string req, input int exp_len, input logic exp_lvl);
    int l; logic v;
    run_phase(l, v);
    chk(req, "phase level", v, exp_lvl);
    chk(req, "phase length", l, exp_len);
  endtask

  task automatic t_reset();
    chk("R1", "pwm_out in reset", pwm_out, 1);
    rd_chk("R1", 2'd0, 0);
    rd_chk("R1", 2'd1, 0);
    rd_chk("R1", 2'd2, 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFF2);
    rd_chk("R2", 2'd0, 32'd2);
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'h1234_5678);
    rd_chk("R2", 2'd1, 32'hDEAD_BEEF);
    rd_chk("R2", 2'd2, 32'h1234_5678);
    rd_chk("R2", 2'd3, 32'd0);
    chk("R2", "no output while enable clear", pwm_out, 1);
    wr(2'd0, 32'd0);
    rd_chk("R2", 2'd0, 32'd0);
  endtask

  task automatic t_pwm();
    int l1, l2; logic v;
    wr(2'd1, 32'd3); wr(2'd2, 32'd6);
    start_timer(32'd3, "R3");
    for (int i = 0; i < 2; i++) begin
      expect_phase("R4", 4, 1'b0);
      expect_phase("R4", 7, 1'b1);
    end
    run_phase(l1, v); run_phase(l2, v);
    chk("R4", "period", l1 + l2, 11);
    stop_timer();
  endtask

  task automatic t_sym();
    wr(2'd1, 32'd4); wr(2'd2, 32'd9);
    start_timer(32'd1, "R3");
    for (int i = 0; i < 2; i++) begin
      expect_phase("R5", 5, 1'b0);
      expect_phase("R5", 5, 1'b1);
    end
    stop_timer();
  endtask

  task automatic t_zero();
    wr(2'd1, 32'd0); wr(2'd2, 32'd0);
    start_timer(32'd3, "R6");
    expect_phase("R6", 1, 1'b0);
    expect_phase("R6", 1, 1'b1);
    expect_phase("R6", 1, 1'b0);
    stop_timer();
    wr(2'd2, 32'd5);
    start_timer(32'd1, "R6");
    expect_phase("R6", 1, 1'b0);
    expect_phase("R6", 1, 1'b1);
    stop_timer();
  endtask

  task automatic t_midwrite();
    int l; logic v;
    wr(2'd1, 32'd9); wr(2'd2, 32'd2);
    start_timer(32'd3, "R7");
    fork
      run_phase(l, v);
      begin @(negedge clk); wr(2'd1, 32'd3); end
    join
    chk("R7", "running phase kept old count", l, 10);
    expect_phase("R7", 3, 1'b1);
    expect_phase("R7", 4, 1'b0);
    stop_timer();
  endtask

  task automatic t_mode_switch();
    int l; logic v;
    wr(2'd1, 32'd2); wr(2'd2, 32'd5);
    start_timer(32'd3, "R7");
    expect_phase("R7", 3, 1'b0);
    fork
      run_phase(l, v);
      begin @(negedge clk); wr(2'd0, 32'd1); end
    join
    chk("R7", "high phase during mode clear", l, 6);
    expect_phase("R5", 3, 1'b0);
    expect_phase("R5", 3, 1'b1);
    fork
      run_phase(l, v);
      wr(2'd0, 32'd3);
    join
    chk("R7", "low phase during mode set", l, 3);
    expect_phase("R7", 6, 1'b1);
    stop_timer();
  endtask

  task automatic t_disable();
    int highs = 0;
    wr(2'd1, 32'd7); wr(2'd2, 32'd7);
    start_timer(32'd3, "R8");
    repeat (3) @(negedge clk);
    wr(2'd0, 32'd0);
    @(negedge clk);
    chk("R8", "high one clock after disable", pwm_out, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    chk("R8", "cycles high while disabled", highs, 20);
    start_timer(32'd3, "R8");
    expect_phase("R8", 8, 1'b0);
    stop_timer();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_pwm();
    t_sym();
    t_zero();
    t_midwrite();
    t_mode_switch();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule